// File: doc/BRIEF.md
# Four-Lane Masked Vector Integer Unit

This block holds a file of eight vector registers, each of 64 elements of 64 bits, and applies element-wise integer addition and subtraction to them. The registers are split across four lanes. Lane k stores every element whose index leaves remainder k when divided by four, so one group of four elements moves through the lanes per clock and no operand ever crosses a lane. An operation may take both operands from registers, or take one from a scalar input that is broadcast to every lane.

A length register limits each operation to the leading elements of the vectors. A 64-bit mask register gates which of those elements are written. The mask is built by comparing a vector against the scalar for inequality. A separate command sets every mask bit, and another command reports how many mask bits are set. Elements are loaded through an indexed write port and inspected through a combinational read port. A busy output covers each vector operation from issue to the last write.

Top module: `vec_lane_alu`

## Requirements
- R1: After reset, busy is 0, vecLen is 64, all 64 maskBits are 1 and popCount is 0.
- R2: An element loaded at (register r, index i) while idle reads back at the same register and index through the peek port. Element i is held in lane i mod 4, row i div 4.
- R3: Command code 0 writes dst[i] = a[i] + b[i], and code 1 writes dst[i] = a[i] + scalar. Both are modulo 2^64, and the scalar is applied to every element.
- R4: Subtraction is modulo 2^64 in three orders: code 2 writes a[i] - b[i], code 3 writes scalar - a[i], and code 4 writes a[i] - scalar.
- R5: A vector command (codes 0 to 5) accepted with length L > 0 keeps busy high for exactly ceil(L/4) cycles after the accepting edge. With L = 0, busy stays low and nothing is written.
- R6: Elements whose index is at or above vecLen keep their old destination value.
- R7: Arithmetic writes only the elements whose mask bit is 1. Elements whose mask bit is 0 keep their old value.
- R8: Code 5 sets mask bit i to (a[i] != scalar) for every i below vecLen, whatever the current mask holds. Mask bits at or above vecLen are left unchanged.
- R9: Code 6 sets all 64 mask bits to 1 on the next edge.
- R10: Code 7 loads popCount with the number of 1 bits in the mask, visible after the next edge.
- R11: Code 8 sets vecLen to cmdLen, clamped to a maximum of 64.
- R12: While busy is high, commands and element loads are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present; taken when busy is low |
| cmdOp | input | 4 | Command code (0 to 8) |
| cmdDst | input | 3 | Destination register |
| cmdSrcA | input | 3 | First source register |
| cmdSrcB | input | 3 | Second source register |
| cmdScalar | input | 64 | Scalar operand |
| cmdLen | input | 7 | New length for code 8 |
| loadEn | input | 1 | Element write strobe |
| loadReg | input | 3 | Register to write |
| loadIdx | input | 6 | Element index to write |
| loadData | input | 64 | Element value |
| peekReg | input | 3 | Register to read |
| peekIdx | input | 6 | Element index to read |
| peekData | output | 64 | Element value, combinational |
| busy | output | 1 | Vector operation in progress |
| vecLen | output | 7 | Current vector length |
| maskBits | output | 64 | Current mask, bit i for element i |
| popCount | output | 7 | Last mask population count |

## Verification
The bench sweeps every arithmetic code across short, odd and full lengths, under both a full mask and a mixed mask made by compare. A design that mapped elements to the wrong lane or row, or ran one group too many or too few, would corrupt elements at or past the length boundary. Such a design would also hold busy for the wrong number of cycles. A zero length must leave busy low, because a design that started anyway would write a whole group. A compare run with a short length must leave the upper mask bits alone. A command or load sent during a run must leave the length and the register file unchanged.

// File: rtl/vec_alu_pkg.sv
package vec_alu_pkg;
  localparam int LANES = 4;
  localparam int ELEMS = 64;
  localparam int NREGS = 8;
  localparam int DW    = 64;
  localparam int DEPTH = ELEMS / LANES;
  localparam int GW    = $clog2(DEPTH);
  localparam int RW    = $clog2(NREGS);
  localparam int IW    = $clog2(ELEMS);
  localparam int LW    = $clog2(ELEMS + 1);
  localparam int SW    = $clog2(LANES);

  typedef enum logic [3:0] {
    OP_ADD_VV   = 4'd0,
    OP_ADD_VS   = 4'd1,
    OP_SUB_VV   = 4'd2,
    OP_SUB_SV   = 4'd3,
    OP_SUB_VS   = 4'd4,
    OP_CMPNE    = 4'd5,
    OP_MASK_ALL = 4'd6,
    OP_POP      = 4'd7,
    OP_SET_VL   = 4'd8
  } op_e;

  typedef struct packed {
    logic [GW-1:0]    group;
    op_e              op;
    logic [RW-1:0]    dst;
    logic [RW-1:0]    srcA;
    logic [RW-1:0]    srcB;
    logic [DW-1:0]    scalar;
    logic [LANES-1:0] wrEn;
  } strobe_t;
endpackage

// File: rtl/vec_lane.sv
module vec_lane
  import vec_alu_pkg::*;
#(
  parameter int LANE = 0
) (
  input  logic          clk,
  input  strobe_t       strb,
  input  logic          loadWe,
  input  logic [RW-1:0] loadReg,
  input  logic [GW-1:0] loadRow,
  input  logic [DW-1:0] loadData,
  input  logic [RW-1:0] peekReg,
  input  logic [GW-1:0] peekRow,
  output logic [DW-1:0] peekData,
  output logic          neBit
);
  logic [DW-1:0] mem [NREGS][DEPTH];
  logic [DW-1:0] opA, opB, res;

  assign opA = mem[strb.srcA][strb.group];
  assign opB = mem[strb.srcB][strb.group];
  assign neBit = (opA != strb.scalar);
  assign peekData = mem[peekReg][peekRow];

  always_comb begin
    case (strb.op)
      OP_ADD_VV: res = opA + opB;
      OP_ADD_VS: res = opA + strb.scalar;
      OP_SUB_VV: res = opA - opB;
      OP_SUB_SV: res = strb.scalar - opA;
      OP_SUB_VS: res = opA - strb.scalar;
      default:   res = opA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (strb.wrEn[LANE]) mem[strb.dst][strb.group] <= res;
    else if (loadWe)     mem[loadReg][loadRow] <= loadData;
  end
endmodule

// File: rtl/vec_ctrl.sv
module vec_ctrl
  import vec_alu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdValid,
  input  logic [3:0]       cmdOp,
  input  logic [RW-1:0]    cmdDst,
  input  logic [RW-1:0]    cmdSrcA,
  input  logic [RW-1:0]    cmdSrcB,
  input  logic [DW-1:0]    cmdScalar,
  input  logic [LW-1:0]    cmdLen,
  input  logic [LANES-1:0] neBits,
  output strobe_t          strb,
  output logic             busy,
  output logic [LW-1:0]    vecLen,
  output logic [ELEMS-1:0] maskBits,
  output logic [LW-1:0]    popCount
);
  logic [GW-1:0]    group, lastGroup;
  op_e              opR;
  logic [RW-1:0]    dstR, srcAR, srcBR;
  logic [DW-1:0]    scalarR;
  logic [IW-1:0]    laneIdx [LANES];
  logic [LANES-1:0] laneLive;
  op_e              newOp;

  assign newOp = op_e'(cmdOp);

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      laneIdx[k]  = IW'(int'(group) * LANES + k);
      laneLive[k] = LW'(laneIdx[k]) < vecLen;
    end
    strb.group  = group;
    strb.op     = opR;
    strb.dst    = dstR;
    strb.srcA   = srcAR;
    strb.srcB   = srcBR;
    strb.scalar = scalarR;
    for (int k = 0; k < LANES; k++)
      strb.wrEn[k] = busy && (opR <= OP_SUB_VS) && laneLive[k] && maskBits[laneIdx[k]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      group     <= '0;
      lastGroup <= '0;
      opR       <= OP_ADD_VV;
      dstR      <= '0;
      srcAR     <= '0;
      srcBR     <= '0;
      scalarR   <= '0;
      vecLen    <= LW'(ELEMS);
      maskBits  <= '1;
      popCount  <= '0;
    end else if (busy) begin
      if (opR == OP_CMPNE)
        for (int k = 0; k < LANES; k++)
          if (laneLive[k]) maskBits[laneIdx[k]] <= neBits[k];
      if (group == lastGroup) busy <= 1'b0;
      else                    group <= group + 1'b1;
    end else if (cmdValid) begin
      case (newOp)
        OP_SET_VL:   vecLen <= (cmdLen > LW'(ELEMS)) ? LW'(ELEMS) : cmdLen;
        OP_MASK_ALL: maskBits <= '1;
        OP_POP:      popCount <= LW'($countones(maskBits));
        default: begin
          if (newOp <= OP_CMPNE && vecLen != '0) begin
            busy      <= 1'b1;
            group     <= '0;
            lastGroup <= GW'((vecLen - LW'(1)) / LW'(LANES));
            opR       <= newOp;
            dstR      <= cmdDst;
            srcAR     <= cmdSrcA;
            srcBR     <= cmdSrcB;
            scalarR   <= cmdScalar;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/vec_lane_alu.sv
module vec_lane_alu
  import vec_alu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdValid,
  input  logic [3:0]       cmdOp,
  input  logic [RW-1:0]    cmdDst,
  input  logic [RW-1:0]    cmdSrcA,
  input  logic [RW-1:0]    cmdSrcB,
  input  logic [DW-1:0]    cmdScalar,
  input  logic [LW-1:0]    cmdLen,
  input  logic             loadEn,
  input  logic [RW-1:0]    loadReg,
  input  logic [IW-1:0]    loadIdx,
  input  logic [DW-1:0]    loadData,
  input  logic [RW-1:0]    peekReg,
  input  logic [IW-1:0]    peekIdx,
  output logic [DW-1:0]    peekData,
  output logic             busy,
  output logic [LW-1:0]    vecLen,
  output logic [ELEMS-1:0] maskBits,
  output logic [LW-1:0]    popCount
);
  strobe_t          strb;
  logic [LANES-1:0] neBits;
  logic [DW-1:0]    laneRd [LANES];

  vec_ctrl ctrl (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdDst(cmdDst), .cmdSrcA(cmdSrcA), .cmdSrcB(cmdSrcB),
    .cmdScalar(cmdScalar), .cmdLen(cmdLen), .neBits(neBits),
    .strb(strb), .busy(busy), .vecLen(vecLen), .maskBits(maskBits),
    .popCount(popCount)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic laneLoad;
    assign laneLoad = loadEn && !busy && (loadIdx[SW-1:0] == SW'(k));
    vec_lane #(.LANE(k)) lane (
      .clk(clk), .strb(strb), .loadWe(laneLoad), .loadReg(loadReg),
      .loadRow(loadIdx[IW-1:SW]), .loadData(loadData), .peekReg(peekReg),
      .peekRow(peekIdx[IW-1:SW]), .peekData(laneRd[k]), .neBit(neBits[k])
    );
  end

  assign peekData = laneRd[peekIdx[SW-1:0]];
endmodule

// File: rtl/vec_lane_alu_chk.sv
module vec_lane_alu_chk
  import vec_alu_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cmdValid,
  input logic [3:0]       cmdOp,
  input logic             busy,
  input logic [LW-1:0]    vecLen,
  input logic [ELEMS-1:0] maskBits,
  input logic [LW-1:0]    popCount
);
  logic [7:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rst_n)    busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  p_busy_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busyRun < 8'(DEPTH)));
  p_len_limit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    vecLen <= LW'(ELEMS));
  p_mask_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && !busy && cmdOp == 4'd6) |=> (&maskBits));
  p_pop_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && !busy && cmdOp == 4'd7) |=> (popCount == LW'($countones($past(maskBits)))));
  p_len_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(vecLen));
endmodule

bind vec_lane_alu vec_lane_alu_chk chk (
  .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp), .busy(busy),
  .vecLen(vecLen), .maskBits(maskBits), .popCount(popCount)
);

// File: tb/vec_lane_alu_test.sv
module vec_lane_alu_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] SEQ = 64'h5;
  localparam logic [63:0] SOP = 64'hFFFF_FFFF_FFFF_FFF0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmdValid = 1'b0, loadEn = 1'b0;
  logic [3:0] cmdOp = '0;
  logic [2:0] cmdDst = '0, cmdSrcA = '0, cmdSrcB = '0, loadReg = '0, peekReg = '0;
  logic [63:0] cmdScalar = '0, loadData = '0, peekData;
  logic [6:0] cmdLen = '0, vecLen, popCount;
  logic [5:0] loadIdx = '0, peekIdx = '0;
  logic busy;
  logic [63:0] maskBits;

  logic [63:0] model [8][64];
  logic [63:0] refMask;
  int refVl = 64;
  int checks = 0, fails = 0, busyCycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vec_lane_alu uut (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdDst(cmdDst),
    .cmdSrcA(cmdSrcA), .cmdSrcB(cmdSrcB), .cmdScalar(cmdScalar), .cmdLen(cmdLen),
    .loadEn(loadEn), .loadReg(loadReg), .loadIdx(loadIdx), .loadData(loadData),
    .peekReg(peekReg), .peekIdx(peekIdx), .peekData(peekData), .busy(busy),
    .vecLen(vecLen), .maskBits(maskBits), .popCount(popCount)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] initVal(int r, int i);
    if (i % 3 == 0) return SEQ;
    if (i % 7 == 1) return ~64'(i);
    return {32'(r * 977 + i), 32'(i * 131 + r)};
  endfunction

  function automatic logic [63:0] arith(int op, logic [63:0] a, logic [63:0] b, logic [63:0] s);
    case (op)
      0: return a + b;
      1: return a + s;
      2: return a - b;
      3: return s - a;
      default: return a - s;
    endcase
  endfunction

  task automatic cmd(input int op, input int dst, input int a, input int b,
                     input logic [63:0] sc, input int len);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 4'(op); cmdDst = 3'(dst); cmdSrcA = 3'(a);
    cmdSrcB = 3'(b); cmdScalar = sc; cmdLen = 7'(len);
    @(negedge clk);
    cmdValid = 1'b0;
    busyCycles = 0;
    while (busy && busyCycles < 100) begin
      busyCycles++;
      @(negedge clk);
    end
  endtask

  task automatic modelArith(input int op, input int dst, input int a, input int b, input logic [63:0] sc);
    for (int i = 0; i < refVl; i++)
      if (refMask[i]) model[dst][i] = arith(op, model[a][i], model[b][i], sc);
  endtask

  task automatic modelCmp(input int a, input logic [63:0] sc);
    for (int i = 0; i < refVl; i++) refMask[i] = (model[a][i] != sc);
  endtask

  task automatic compareReg(input int r, input string req);
    logic [63:0] act, exp;
    bit ok = 1'b1;
    act = '0; exp = '0;
    for (int i = 0; i < 64; i++) begin
      peekReg = 3'(r); peekIdx = 6'(i);
      #1;
      if (ok && peekData !== model[r][i]) begin
        ok = 1'b0; act = peekData; exp = model[r][i];
      end
    end
    check(ok, req, act, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("%0d/%0d checks passed", checks - fails, checks + 0);
    $finish;
  end

  initial begin
    int lens [4];
    lens = '{64, 17, 1, 6};
    refMask = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", 64'(busy), 0);
    check(vecLen == 7'd64, "R1 vecLen", 64'(vecLen), 64);
    check(maskBits == '1, "R1 maskBits", maskBits, '1);
    check(popCount == 7'd0, "R1 popCount", 64'(popCount), 0);

    // R2 load every element, then read back
    for (int r = 0; r < 8; r++)
      for (int i = 0; i < 64; i++) begin
        @(negedge clk);
        loadEn = 1'b1; loadReg = 3'(r); loadIdx = 6'(i);
        loadData = initVal(r, i); model[r][i] = initVal(r, i);
      end
    @(negedge clk);
    loadEn = 1'b0;
    for (int r = 0; r < 8; r++) compareReg(r, "R2 load/peek");

    // R3 R4 R5 R6 R7 sweep
    for (int op = 0; op < 5; op++)
      for (int li = 0; li < 4; li++)
        for (int mm = 0; mm < 2; mm++) begin
          cmd(8, 0, 0, 0, '0, 64); refVl = 64;
          if (mm == 0) begin
            cmd(6, 0, 0, 0, '0, 0); refMask = '1;
          end else begin
            cmd(5, 0, 3, 0, SEQ, 0); modelCmp(3, SEQ);
            if (op == 0 && li == 0) check(maskBits == refMask, "R8 compare mask", maskBits, refMask);
          end
          cmd(8, 0, 0, 0, '0, lens[li]); refVl = lens[li];
          cmd(op, 7, 1, 2, SOP, 0);
          modelArith(op, 7, 1, 2, SOP);
          check(busyCycles == (refVl + 3) / 4, "R5 busy length", 64'(busyCycles), 64'((refVl + 3) / 4));
          compareReg(7, (op < 2) ? "R3 R6 R7 add result" : "R4 R6 R7 sub result");
        end

    // R8 compare with short length keeps upper mask bits
    cmd(8, 0, 0, 0, '0, 64); refVl = 64;
    cmd(6, 0, 0, 0, '0, 0); refMask = '1;
    check(maskBits == '1, "R9 mask all ones", maskBits, '1);
    cmd(8, 0, 0, 0, '0, 10); refVl = 10;
    cmd(5, 0, 4, 0, SEQ, 0); modelCmp(4, SEQ);
    check(maskBits == refMask, "R8 short compare", maskBits, refMask);
    check(busyCycles == 3, "R5 compare busy", 64'(busyCycles), 3);

    // R10 population count
    cmd(7, 0, 0, 0, '0, 0);
    check(popCount == 7'($countones(refMask)), "R10 popCount", 64'(popCount), 64'($countones(refMask)));
    cmd(6, 0, 0, 0, '0, 0); refMask = '1;
    check(maskBits == '1, "R9 mask refill", maskBits, '1);
    cmd(7, 0, 0, 0, '0, 0);
    check(popCount == 7'd64, "R10 popCount full", 64'(popCount), 64);

    // R11 clamp
    cmd(8, 0, 0, 0, '0, 100);
    check(vecLen == 7'd64, "R11 clamp", 64'(vecLen), 64);
    cmd(8, 0, 0, 0, '0, 37);
    check(vecLen == 7'd37, "R11 set", 64'(vecLen), 37);

    // R5 zero length does nothing
    cmd(8, 0, 0, 0, '0, 0); refVl = 0;
    cmd(0, 5, 1, 2, SOP, 0);
    check(busyCycles == 0, "R5 zero length busy", 64'(busyCycles), 0);
    compareReg(5, "R5 zero length untouched");

    // R12 command and load ignored while busy
    cmd(8, 0, 0, 0, '0, 64); refVl = 64;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 4'd0; cmdDst = 3'd6; cmdSrcA = 3'd1; cmdSrcB = 3'd2;
    @(negedge clk);
    cmdOp = 4'd8; cmdLen = 7'd3;
    loadEn = 1'b1; loadReg = 3'd0; loadIdx = 6'd0; loadData = 64'hDEAD;
    @(negedge clk);
    cmdValid = 1'b0; loadEn = 1'b0;
    while (busy) @(negedge clk);
    modelArith(0, 6, 1, 2, '0);
    check(vecLen == 7'd64, "R12 length kept", 64'(vecLen), 64);
    compareReg(0, "R12 load ignored");
    compareReg(6, "R12 R3 result during ignore");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule